// File: doc/BRIEF.md
# Integer PLL Divider Search Engine

This block walks the legal integer settings of a PLL whose oscillator runs at twice the multiplier times the divided reference. Given the input clock rate, the wanted oscillator window and the hardware limits, it finds the range of pre-divider values N. For each N it finds the range of multiplier values M. It then offers every (N, M) pair in turn, together with the divided reference rate and the oscillator rate, so that a consumer can judge each candidate.

The consumer takes each candidate on a valid/ready handshake. It raises an accept flag on the handshake of the candidate it wants, and the search stops there. If no candidate is accepted, the engine reports that it found nothing once every N has been visited. All divisions share one iterative divider, which keeps the datapath small. A mode input reverses the order in which both loops are walked, to work around a part defect.

Top module: `pll_nm_search`

## Requirements
- R1: The N range runs from max(ceil(clkin_rate / fref_ceil), 1) to min(floor(clkin_rate / fref_floor), n_cap), both ends included. If the first value is above the last, no candidate is offered.
- R2: For each N, cand_fref equals floor(clkin_rate / N).
- R3: For each N, the M range runs from max(ceil(ceil(dco_lo_req / fref) / 2), 1) to the smallest of floor(floor(dco_hi_req / fref) / 2), floor(floor(dco_hw_ceil / fref) / 2) and m_cap.
- R4: cand_dco equals 2 × cand_m × cand_fref.
- R5: A dco_hi_req of zero places no limit on the M range and acts as the all-ones value.
- R6: With errata_mode low, N ascends in the outer loop and M ascends in the inner loop. With errata_mode high, both descend from their upper bound to their lower bound.
- R7: While cand_valid is high and cand_ready is low, the candidate fields stay unchanged. Each cycle with both high consumes exactly one candidate.
- R8: A handshake with cand_accept high ends the search. done pulses on the next cycle with found high, and no further candidate is offered.
- R9: An N whose M range is empty is skipped. When all N values are used up, or the N range is empty, done pulses with found low.
- R10: After reset, busy, done, found and cand_valid are low. A start pulse while busy is high is ignored.
- R11: done is a one-cycle pulse and busy is low in that cycle. found keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled when idle) |
| errata_mode | input | 1 | Walk both loops downward |
| clkin_rate | input | RATE_W | Input clock rate |
| dco_lo_req | input | RATE_W | Requested minimum oscillator rate |
| dco_hi_req | input | RATE_W | Requested maximum oscillator rate, 0 = unlimited |
| fref_floor | input | RATE_W | Minimum allowed divided reference |
| fref_ceil | input | RATE_W | Maximum allowed divided reference |
| dco_hw_ceil | input | RATE_W | Hardware oscillator maximum |
| n_cap | input | N_W | Hardware maximum of N |
| m_cap | input | M_W | Hardware maximum of M |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_accept | input | 1 | Consumer stops the search on this candidate |
| cand_n | output | N_W | Candidate pre-divider |
| cand_m | output | M_W | Candidate multiplier |
| cand_fref | output | RATE_W | Candidate divided reference |
| cand_dco | output | RATE_W+M_W+1 | Candidate oscillator rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished (pulse) |
| found | output | 1 | Last search ended on an accepted candidate |

## Verification
The bench aims at the edges of the loop bounds. It covers ceiling rounding of the first N and first M, N clipped by n_cap, and M clipped by m_cap and by the hardware oscillator limit. A design that floors instead of rounding up, or that stops one step short, shows up as a candidate sequence that differs from the bench's own enumeration or as a wrong total count. The bench covers empty N and M ranges, which must end with found low rather than offering a stray pair, and the unlimited upper request, which a design treating zero literally would turn into an empty M range. It also covers reversed walking, acceptance of the very first and very last candidate, handshake stalls, and a stray start pulse mid-search, which a careless design would treat as a restart that replays earlier candidates.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NLO,
    ST_NHI,
    ST_NCHK,
    ST_FREF,
    ST_MLO,
    ST_MA,
    ST_MB,
    ST_MCHK,
    ST_OFFER
  } srch_state_t;

  function automatic logic uses_div(srch_state_t s);
    return (s == ST_NLO) || (s == ST_NHI) || (s == ST_FREF) ||
           (s == ST_MLO) || (s == ST_MA)  || (s == ST_MB);
  endfunction

endpackage

// File: rtl/pll_iter_div.sv
module pll_iter_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, den};
    fits    = ~diff[W+1];
    rem_d   = rem_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      quo_d  = num;
      cnt_d  = CW'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

  // R2
  div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

endmodule

// File: rtl/pll_loop_idx.sv
module pll_loop_idx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         down,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load)      idx_d = down ? hi : lo;
    else if (step) idx_d = down ? idx_q - 1'b1 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx  = idx_q;
  assign last = down ? (idx_q == lo) : (idx_q == hi);

  // R6
  step_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !last);

endmodule

// File: rtl/pll_nm_search.sv
module pll_nm_search
  import pll_search_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int N_W    = 8,
  parameter int M_W    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     errata_mode,
  input  logic [RATE_W-1:0]        clkin_rate,
  input  logic [RATE_W-1:0]        dco_lo_req,
  input  logic [RATE_W-1:0]        dco_hi_req,
  input  logic [RATE_W-1:0]        fref_floor,
  input  logic [RATE_W-1:0]        fref_ceil,
  input  logic [RATE_W-1:0]        dco_hw_ceil,
  input  logic [N_W-1:0]           n_cap,
  input  logic [M_W-1:0]           m_cap,
  output logic                     cand_valid,
  input  logic                     cand_ready,
  input  logic                     cand_accept,
  output logic [N_W-1:0]           cand_n,
  output logic [M_W-1:0]           cand_m,
  output logic [RATE_W-1:0]        cand_fref,
  output logic [RATE_W+M_W:0]      cand_dco,
  output logic                     busy,
  output logic                     done,
  output logic                     found
);
  localparam int RW = RATE_W;
  localparam int DW = RATE_W + M_W + 1;
  localparam logic [RW-1:0] ONE = RW'(1);

  srch_state_t state_q, state_d;
  logic [RW-1:0] n_lo_q, n_lo_d, n_hi_q, n_hi_d;
  logic [RW-1:0] m_lo_q, m_lo_d, m_hi_q, m_hi_d;
  logic [RW-1:0] ma_q, ma_d, fref_q, fref_d;
  logic          kick_q, kick_d, done_q, done_d, found_q, found_d;

  logic          n_load, n_step, m_load, m_step, next_n;
  logic [RW-1:0] n_idx, m_idx;
  logic          n_last, m_last;

  logic [RW-1:0] div_num, div_den, div_quo, div_rem;
  logic          div_busy, div_done;

  logic [RW-1:0] ceil_q, hi_eff, n_cap_w, m_cap_w, half_b, m_min2;
  logic [RW:0]   half_sum;

  // operand selection follows the current dividing state
  always_comb begin
    div_num = clkin_rate;
    div_den = fref_ceil;
    unique case (state_q)
      ST_NHI:  div_den = fref_floor;
      ST_FREF: div_den = n_idx;
      ST_MLO:  begin div_num = dco_lo_req;  div_den = fref_q; end
      ST_MA:   begin div_num = hi_eff;      div_den = fref_q; end
      ST_MB:   begin div_num = dco_hw_ceil; div_den = fref_q; end
      default: ;
    endcase
  end

  pll_iter_div #(.W(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(kick_q), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  pll_loop_idx #(.W(RW)) u_nidx (
    .clk(clk), .rst_n(rst_n), .load(n_load), .step(n_step), .down(errata_mode),
    .lo(n_lo_q), .hi(n_hi_q), .idx(n_idx), .last(n_last)
  );

  pll_loop_idx #(.W(RW)) u_midx (
    .clk(clk), .rst_n(rst_n), .load(m_load), .step(m_step), .down(errata_mode),
    .lo(m_lo_q), .hi(m_hi_q), .idx(m_idx), .last(m_last)
  );

  // shared arithmetic on divider results
  always_comb begin
    hi_eff   = (dco_hi_req == '0) ? '1 : dco_hi_req;
    ceil_q   = (div_rem != '0 && div_quo != '1) ? div_quo + ONE : div_quo;
    half_sum = {1'b0, ceil_q} + {{RW{1'b0}}, 1'b1};
    n_cap_w  = {{(RW-N_W){1'b0}}, n_cap};
    m_cap_w  = {{(RW-M_W){1'b0}}, m_cap};
    half_b   = div_quo >> 1;
    m_min2   = (ma_q < half_b) ? ma_q : half_b;
  end

  always_comb begin
    state_d = state_q;
    n_lo_d  = n_lo_q;
    n_hi_d  = n_hi_q;
    m_lo_d  = m_lo_q;
    m_hi_d  = m_hi_q;
    ma_d    = ma_q;
    fref_d  = fref_q;
    done_d  = 1'b0;
    found_d = found_q;
    n_load  = 1'b0;
    n_step  = 1'b0;
    m_load  = 1'b0;
    m_step  = 1'b0;
    next_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        found_d = 1'b0;
        state_d = ST_NLO;
      end
      ST_NLO: if (div_done) begin
        n_lo_d  = (ceil_q == '0) ? ONE : ceil_q;
        state_d = ST_NHI;
      end
      ST_NHI: if (div_done) begin
        n_hi_d  = (div_quo < n_cap_w) ? div_quo : n_cap_w;
        state_d = ST_NCHK;
      end
      ST_NCHK: if (n_lo_q > n_hi_q) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end else begin
        n_load  = 1'b1;
        state_d = ST_FREF;
      end
      ST_FREF: if (div_done) begin
        fref_d  = div_quo;
        state_d = ST_MLO;
      end
      ST_MLO: if (div_done) begin
        m_lo_d  = (half_sum[RW:1] == '0) ? ONE : half_sum[RW:1];
        state_d = ST_MA;
      end
      ST_MA: if (div_done) begin
        ma_d    = half_b;
        state_d = ST_MB;
      end
      ST_MB: if (div_done) begin
        m_hi_d  = (m_min2 < m_cap_w) ? m_min2 : m_cap_w;
        state_d = ST_MCHK;
      end
      ST_MCHK: if (m_lo_q > m_hi_q) begin
        next_n = 1'b1;
      end else begin
        m_load  = 1'b1;
        state_d = ST_OFFER;
      end
      ST_OFFER: if (cand_ready) begin
        if (cand_accept) begin
          done_d  = 1'b1;
          found_d = 1'b1;
          state_d = ST_IDLE;
        end else if (m_last) begin
          next_n = 1'b1;
        end else begin
          m_step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (next_n) begin
      if (n_last) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end else begin
        n_step  = 1'b1;
        state_d = ST_FREF;
      end
    end
    kick_d = uses_div(state_d) && (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      n_lo_q  <= '0;
      n_hi_q  <= '0;
      m_lo_q  <= '0;
      m_hi_q  <= '0;
      ma_q    <= '0;
      fref_q  <= '0;
      kick_q  <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      state_q <= state_d;
      n_lo_q  <= n_lo_d;
      n_hi_q  <= n_hi_d;
      m_lo_q  <= m_lo_d;
      m_hi_q  <= m_hi_d;
      ma_q    <= ma_d;
      fref_q  <= fref_d;
      kick_q  <= kick_d;
      done_q  <= done_d;
      found_q <= found_d;
    end
  end

  assign cand_valid = (state_q == ST_OFFER);
  assign cand_n     = n_idx[N_W-1:0];
  assign cand_m     = m_idx[M_W-1:0];
  assign cand_fref  = fref_q;
  assign cand_dco   = ({{(DW-RW){1'b0}}, fref_q} * {{(DW-M_W){1'b0}}, cand_m}) << 1;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign found      = found_q;

  // R7
  hold_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_n) &&
                                  $stable(cand_m) && $stable(cand_dco));

  // R8
  accept_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready && cand_accept |=> done && found && !cand_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cand_valid);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done_d |=> busy);

endmodule

// File: tb/sim_pll_nm_search.sv
module sim_pll_nm_search;
  localparam int RW = 32;
  localparam int NW = 8;
  localparam int MW = 12;

  typedef struct packed {
    int unsigned clkin;
    int unsigned dmin;
    int unsigned dmax;
    int unsigned fmin;
    int unsigned fmax;
    int unsigned hw;
    int unsigned nlim;
    int unsigned mlim;
    bit          errata;
    int          acc;
    int unsigned ecnt;
    bit          efound;
    bit          stall;
    bit          poke;
  } vec_t;

  // clkin dmin dmax fmin fmax hw nlim mlim errata acc ecnt efound stall poke
  localparam vec_t VECS [0:7] = '{
    '{1000, 2000,   3000, 100, 300, 5000, 16, 100, 1'b0, -1, 27, 1'b0, 1'b0, 1'b0},
    '{1000, 2000,   3000, 100, 300, 5000, 16, 100, 1'b1,  0,  1, 1'b1, 1'b0, 1'b0},
    '{1000, 2000,   3000, 100, 300, 5000, 16, 100, 1'b0,  4,  5, 1'b1, 1'b1, 1'b0},
    '{1000, 1000,      0, 200, 500, 2400,  8,   3, 1'b0, -1,  7, 1'b0, 1'b0, 1'b0},
    '{1000, 2000,   3000, 600, 700, 5000, 16, 100, 1'b0, -1,  0, 1'b0, 1'b0, 1'b0},
    '{1000, 100000, 3000, 100, 300, 5000, 16, 100, 1'b0, -1,  0, 1'b0, 1'b0, 1'b0},
    '{1000, 2000,   3000, 100, 300, 5000,  5, 100, 1'b1, -1,  6, 1'b0, 1'b1, 1'b1},
    '{1000, 2000,   3000, 100, 300, 5000, 16, 100, 1'b0, 26, 27, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, start, errata_mode, cand_ready, cand_accept;
  logic [RW-1:0] clkin_rate, dco_lo_req, dco_hi_req, fref_floor, fref_ceil, dco_hw_ceil;
  logic [NW-1:0] n_cap;
  logic [MW-1:0] m_cap;
  logic cand_valid, busy, done, found;
  logic [NW-1:0] cand_n;
  logic [MW-1:0] cand_m;
  logic [RW-1:0] cand_fref;
  logic [RW+MW:0] cand_dco;

  int total = 0;
  int bad = 0;
  int exp_cnt;
  longint exp_n [0:63];
  longint exp_m [0:63];
  longint exp_f [0:63];
  longint exp_d [0:63];

  always #4 clk = ~clk;

  pll_nm_search #(.RATE_W(RW), .N_W(NW), .M_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .errata_mode(errata_mode),
    .clkin_rate(clkin_rate), .dco_lo_req(dco_lo_req), .dco_hi_req(dco_hi_req),
    .fref_floor(fref_floor), .fref_ceil(fref_ceil), .dco_hw_ceil(dco_hw_ceil),
    .n_cap(n_cap), .m_cap(m_cap), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_accept(cand_accept), .cand_n(cand_n), .cand_m(cand_m), .cand_fref(cand_fref),
    .cand_dco(cand_dco), .busy(busy), .done(done), .found(found)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  // independent enumeration of the candidate sequence (R1 R2 R3 R4 R5 R6)
  task automatic build_model(input vec_t v);
    longint nlo, nhi, dmx;
    exp_cnt = 0;
    dmx = (v.dmax == 0) ? longint'(32'hFFFF_FFFF) : longint'(v.dmax);
    nlo = cdiv(v.clkin, v.fmax);
    if (nlo < 1) nlo = 1;
    nhi = v.clkin / v.fmin;
    if (nhi > v.nlim) nhi = v.nlim;
    for (longint i = 0; i <= nhi - nlo; i++) begin
      longint n, f, mlo, mhi;
      n = v.errata ? nhi - i : nlo + i;
      f = v.clkin / n;
      mlo = cdiv(cdiv(v.dmin, f), 2);
      if (mlo < 1) mlo = 1;
      mhi = (dmx / f) / 2;
      if ((v.hw / f) / 2 < mhi) mhi = (v.hw / f) / 2;
      if (v.mlim < mhi) mhi = v.mlim;
      for (longint j = 0; j <= mhi - mlo; j++) begin
        if (exp_cnt < 64) begin
          exp_n[exp_cnt] = n;
          exp_m[exp_cnt] = v.errata ? mhi - j : mlo + j;
          exp_f[exp_cnt] = f;
          exp_d[exp_cnt] = 2 * exp_m[exp_cnt] * f;
        end
        exp_cnt++;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    int seen = 0;
    int guard = 0;
    bit fin = 0;
    bit held = 0;
    logic [NW-1:0] hn;
    logic [MW-1:0] hm;
    build_model(v);
    @(negedge clk);
    clkin_rate = v.clkin; dco_lo_req = v.dmin; dco_hi_req = v.dmax;
    fref_floor = v.fmin; fref_ceil = v.fmax; dco_hw_ceil = v.hw;
    n_cap = NW'(v.nlim); m_cap = MW'(v.mlim); errata_mode = v.errata;
    cand_ready = 1'b0; cand_accept = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: busy from the cycle after start
    check(busy === 1'b1, "R11 busy after start", busy, 1);
    while (!fin && guard < 30000) begin
      start = 1'b0;
      if (done) begin
        fin = 1;
        // R1 R9: count of candidates
        check(seen == int'(v.ecnt), $sformatf("R1/R9 count vec%0d", vi), seen, v.ecnt);
        check(v.acc >= 0 || seen == exp_cnt, $sformatf("R3 model count vec%0d", vi), seen, exp_cnt);
        // R8 R9: found
        check(found === v.efound, $sformatf("R8/R9 found vec%0d", vi), found, v.efound);
        check(busy === 1'b0, "R11 busy low at done", busy, 0);
        cand_ready = 1'b0; cand_accept = 1'b0;
      end else begin
        if (held) begin
          // R7: fields held while stalled
          check(cand_valid && cand_n == hn && cand_m == hm,
                $sformatf("R7 hold vec%0d", vi), cand_m, hm);
        end
        cand_ready  = v.stall ? guard[0] : 1'b1;
        cand_accept = 1'b0;
        held = cand_valid && !cand_ready;
        hn = cand_n; hm = cand_m;
        if (cand_valid && cand_ready) begin
          if (seen < 64) begin
            // R2 R3 R4 R6: candidate matches enumeration order
            check(cand_n == exp_n[seen] && cand_m == exp_m[seen] &&
                  cand_fref == exp_f[seen] && longint'(cand_dco) == exp_d[seen],
                  $sformatf("R2/R3/R4/R6 cand %0d vec%0d n=%0d", seen, vi, cand_n),
                  cand_m, exp_m[seen]);
          end
          cand_accept = (seen == v.acc);
          // R10: a stray start while busy must not restart the walk
          if (v.poke && seen == 2) start = 1'b1;
          seen++;
        end
        @(negedge clk);
        guard++;
      end
    end
    check(fin, $sformatf("R9 search ends vec%0d", vi), fin, 1);
    repeat (3) begin
      @(negedge clk);
      // R8 R11: nothing offered after the end, done single pulse, found kept
      check(!cand_valid && !done && found === v.efound,
            $sformatf("R8/R11 after done vec%0d", vi), done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; errata_mode = 1'b0;
    cand_ready = 1'b0; cand_accept = 1'b0;
    clkin_rate = '0; dco_lo_req = '0; dco_hi_req = '0;
    fref_floor = 32'd1; fref_ceil = 32'd1; dco_hw_ceil = '0;
    n_cap = '0; m_cap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busy === 1'b0, "R10 reset busy", busy, 0);
    check(done === 1'b0, "R10 reset done", done, 0);
    check(found === 1'b0, "R10 reset found", found, 0);
    check(cand_valid === 1'b0, "R10 reset valid", cand_valid, 0);
    // table walk; vec3 covers R5, vec4 empty N, vec5 empty M, vec6 R10 poke
    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);
    // R11: found cleared by a new start (vec4 after an accepted vec)
    run_vec(VECS[1], 8);
    run_vec(VECS[4], 9);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule